// File: doc/BRIEF.md
# Byte and Word Addressable Memory Unit

This block sits between a small processor and its on-chip storage so that the processor sees one flat, byte-addressed space and never deals with how the storage is organised. A 16-bit byte address selects a location. Behind that address sit 1024 bytes of RAM and two memory-mapped registers that drive an 8-bit general-purpose pin port. A write stores either one byte or a whole 16-bit little-endian word, depending on a size control. Any cycle without a write is a read. Read data appears on a 16-bit output one clock later.

The RAM is split into an even-byte bank and an odd-byte bank, so a word access uses both banks in one cycle. A small read-path state machine records in state `ST_IDLE`, `ST_RAM_BYTE`, `ST_RAM_WORD`, `ST_PORT_PINS`, `ST_PORT_DIR`, `ST_PORT_WORD` or `ST_ZERO` what kind of access was issued on the previous edge. The output process then forms the read data from that state. The state is re-decoded on every edge from the request in progress:
- a write goes to `ST_IDLE`;
- a RAM read goes to `ST_RAM_BYTE` or `ST_RAM_WORD`;
- a read at the port pair goes to `ST_PORT_PINS`, `ST_PORT_DIR` or `ST_PORT_WORD`;
- any other read goes to `ST_ZERO`.

Reset forces `ST_IDLE`. A word write to an odd address is dropped and sets a sticky error flag.

Top module: `bytemem_unit`

## Requirements
- R1: Addresses 0 to 1023 hold one RAM byte each. A byte write (wr_en=1, word_wr=0) stores wdata[7:0] at addr and leaves every other byte unchanged, including the other byte of the same word pair.
- R2: A word write (wr_en=1, word_wr=1) at an even address stores wdata[7:0] at addr and wdata[15:8] at addr+1 (little-endian).
- R3: A word write at any odd address changes neither the RAM nor the port registers, and it sets misalign to 1. misalign stays 1 until reset and is 0 after reset.
- R4: A read (wr_en=0) is presented on rdata one clock after the edge that samples it. A byte read returns the addressed byte in rdata[7:0] with rdata[15:8]=0. A word read returns {byte at addr|1, byte at addr with bit 0 cleared}.
- R5: rdata is 0 after reset and in the cycle that follows a write. During reset gpio_o, gpio_oe and misalign are 0.
- R6: A byte write at 0xFF00 loads the port output register, shown on gpio_o. A byte write at 0xFF01 loads the direction mask, shown on gpio_oe, where 1 makes a pin an output. A word write at 0xFF00 loads the output register from wdata[7:0] and the mask from wdata[15:8].
- R7: A byte read at 0xFF00 returns the live pin levels: gpio_o where the mask bit is 1 and gpio_i where it is 0, taken at the sampling edge. A byte read at 0xFF01 returns the mask. A word read at 0xFF00 or 0xFF01 returns {mask, live levels}.
- R8: Addresses from 1024 up, other than 0xFF00 and 0xFF01, read as 0. Byte writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 16 | Byte address |
| wr_en | input | 1 | 1 = write this cycle, 0 = read |
| word_wr | input | 1 | Access size: 1 = 16-bit word, 0 = byte |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, one cycle after the request |
| gpio_i | input | 8 | Levels seen on the port pins |
| gpio_o | output | 8 | Port output register |
| gpio_oe | output | 8 | Port direction mask, 1 = output |
| misalign | output | 1 | Sticky flag for a dropped odd word write |

## Verification
The assertions assume that the request inputs are free of X and hold steady across each rising edge. The bench meets this by changing them only on the falling edge. The assertions also assume that rdata is read only in the cycle right after the request, so the bench samples every result one falling edge after it drives the request. The RAM has no reset, so the bench first fills the whole RAM with word writes and keeps a model of its contents. After that it mixes random RAM, port and out-of-range accesses of both sizes, including odd word writes, which the assertions treat as legal.

// File: rtl/bytemem_pkg.sv
package bytemem_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAM_BYTE,
        ST_RAM_WORD,
        ST_PORT_PINS,
        ST_PORT_DIR,
        ST_PORT_WORD,
        ST_ZERO
    } rd_state_t;
endpackage

// File: rtl/bytemem_bank.sv
module bytemem_bank #(
    parameter int DEPTH = 512,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       wbyte,
    output logic [7:0]       rbyte
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[idx] <= wbyte;
        rbyte <= cells[idx];
    end
endmodule

// File: rtl/bytemem_decode.sv
module bytemem_decode #(
    parameter int ADDR_W    = 16,
    parameter int RAM_BYTES = 1024,
    parameter logic [ADDR_W-1:0] PORT_BASE = 16'hFF00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              word_wr,
    output logic              in_ram,
    output logic              in_port,
    output logic              bad_word,
    output logic [1:0]        lane_we,
    output logic              out_we,
    output logic              dir_we
);
    always_comb begin
        in_ram   = (32'(addr) < RAM_BYTES);
        in_port  = (addr[ADDR_W-1:1] == PORT_BASE[ADDR_W-1:1]);
        bad_word = wr_en && word_wr && addr[0];
        lane_we[0] = wr_en && in_ram && !addr[0];
        lane_we[1] = wr_en && in_ram && (word_wr ? !addr[0] : addr[0]);
        out_we   = wr_en && in_port && !addr[0];
        dir_we   = wr_en && in_port && (word_wr ? !addr[0] : addr[0]);
    end
endmodule

// File: rtl/bytemem_gpio.sv
module bytemem_gpio #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          out_we,
    input  logic          dir_we,
    input  logic [PW-1:0] out_d,
    input  logic [PW-1:0] dir_d,
    input  logic [PW-1:0] pins_i,
    output logic [PW-1:0] out_q,
    output logic [PW-1:0] dir_q,
    output logic [PW-1:0] live
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '0;
        end else begin
            if (out_we) out_q <= out_d;
            if (dir_we) dir_q <= dir_d;
        end
    end

    assign live = (dir_q & out_q) | (~dir_q & pins_i);
endmodule

// File: rtl/bytemem_unit.sv
module bytemem_unit #(
    parameter int ADDR_W    = 16,
    parameter int RAM_BYTES = 1024,
    parameter logic [ADDR_W-1:0] PORT_BASE = 16'hFF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              word_wr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    input  logic [7:0]        gpio_i,
    output logic [7:0]        gpio_o,
    output logic [7:0]        gpio_oe,
    output logic              misalign
);
    import bytemem_pkg::*;

    localparam int IDX_W      = $clog2(RAM_BYTES) - 1;
    localparam int BANK_DEPTH = RAM_BYTES / 2;

    logic       in_ram, in_port, bad_word, out_we, dir_we;
    logic [1:0] lane_we;
    logic [7:0] lane_q [2];
    logic [7:0] live;
    rd_state_t  state, state_nxt;
    logic       lane_sel;
    logic [15:0] snap;

    bytemem_decode #(.ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .PORT_BASE(PORT_BASE)) u_dec (
        .addr(addr), .wr_en(wr_en), .word_wr(word_wr),
        .in_ram(in_ram), .in_port(in_port), .bad_word(bad_word),
        .lane_we(lane_we), .out_we(out_we), .dir_we(dir_we)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [7:0] wb;
        assign wb = (g == 1 && word_wr) ? wdata[15:8] : wdata[7:0];
        bytemem_bank #(.DEPTH(BANK_DEPTH), .IDX_W(IDX_W)) u_bank (
            .clk(clk), .we(lane_we[g]), .idx(addr[IDX_W:1]),
            .wbyte(wb), .rbyte(lane_q[g])
        );
    end

    bytemem_gpio #(.PW(8)) u_gpio (
        .clk(clk), .rst_n(rst_n), .out_we(out_we), .dir_we(dir_we),
        .out_d(wdata[7:0]), .dir_d(word_wr ? wdata[15:8] : wdata[7:0]),
        .pins_i(gpio_i), .out_q(gpio_o), .dir_q(gpio_oe), .live(live)
    );

    always_comb begin
        if (wr_en)        state_nxt = ST_IDLE;
        else if (in_ram)  state_nxt = word_wr ? ST_RAM_WORD : ST_RAM_BYTE;
        else if (in_port) state_nxt = word_wr ? ST_PORT_WORD :
                                      (addr[0] ? ST_PORT_DIR : ST_PORT_PINS);
        else              state_nxt = ST_ZERO;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lane_sel <= 1'b0;
            snap     <= '0;
            misalign <= 1'b0;
        end else begin
            state    <= state_nxt;
            lane_sel <= addr[0];
            snap     <= {gpio_oe, live};
            if (bad_word) misalign <= 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:      rdata = '0;
            ST_RAM_BYTE:  rdata = {8'h00, lane_sel ? lane_q[1] : lane_q[0]};
            ST_RAM_WORD:  rdata = {lane_q[1], lane_q[0]};
            ST_PORT_PINS: rdata = {8'h00, snap[7:0]};
            ST_PORT_DIR:  rdata = {8'h00, snap[15:8]};
            ST_PORT_WORD: rdata = snap;
            ST_ZERO:      rdata = '0;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/bytemem_unit_chk.sv
module bytemem_unit_chk #(
    parameter int ADDR_W    = 16,
    parameter int RAM_BYTES = 1024,
    parameter logic [ADDR_W-1:0] PORT_BASE = 16'hFF00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              word_wr,
    input logic [15:0]       wdata,
    input logic [15:0]       rdata,
    input logic [7:0]        gpio_o,
    input logic [7:0]        gpio_oe,
    input logic              misalign
);
    logic port_pair, far;
    assign port_pair = (addr[ADDR_W-1:1] == PORT_BASE[ADDR_W-1:1]);
    assign far       = (32'(addr) >= RAM_BYTES) && !port_pair;

    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> misalign);
    assert_odd_word_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_wr && addr[0]) |=> misalign);
    assert_write_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rdata == 16'h0000));
    assert_byte_read_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !word_wr) |=> (rdata[15:8] == 8'h00));
    assert_far_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && far) |=> (rdata == 16'h0000));
    assert_out_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == PORT_BASE) |=> (gpio_o == $past(wdata[7:0])));
    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == PORT_BASE) |=> $stable(gpio_o));
    assert_dir_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && port_pair && (word_wr ? !addr[0] : addr[0])) |=> $stable(gpio_oe));
endmodule

bind bytemem_unit bytemem_unit_chk #(.ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .PORT_BASE(PORT_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .word_wr(word_wr),
    .wdata(wdata), .rdata(rdata), .gpio_o(gpio_o), .gpio_oe(gpio_oe), .misalign(misalign)
);

// File: tb/bytemem_unit_tb.sv
module bytemem_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [15:0] addr = 16'h2000, wdata = '0;
    logic wr_en = 1'b0, word_wr = 1'b0;
    logic [7:0] gpio_i = '0;
    logic [15:0] rdata;
    logic [7:0] gpio_o, gpio_oe;
    logic misalign;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic [7:0] mdl [1024];
    logic [7:0] m_out = '0, m_dir = '0;
    logic m_mis = 1'b0;

    bytemem_unit u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .word_wr(word_wr),
        .wdata(wdata), .rdata(rdata), .gpio_i(gpio_i), .gpio_o(gpio_o),
        .gpio_oe(gpio_oe), .misalign(misalign)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [15:0] a, input logic ww, input logic [7:0] gi);
        logic [7:0] live;
        logic [15:0] al;
        live = (m_dir & m_out) | (~m_dir & gi);
        al = {a[15:1], 1'b0};
        if (a < 16'd1024) begin
            if (ww) return {mdl[al + 16'd1], mdl[al]};
            return {8'h00, mdl[a]};
        end else if (a[15:1] == 15'h7F80) begin
            if (ww) return {m_dir, live};
            return a[0] ? {8'h00, m_dir} : {8'h00, live};
        end
        return 16'h0000;
    endfunction

    function automatic string tag_of(input logic we, input logic ww, input logic [15:0] a);
        if (we) return "R5";
        if (a < 16'd1024) return ww ? "R4" : "R1";
        if (a[15:1] == 15'h7F80) return "R7";
        return "R8";
    endfunction

    task automatic model_write(input logic ww, input logic [15:0] a, input logic [15:0] d);
        if (ww && a[0]) begin
            m_mis = 1'b1;
        end else if (a < 16'd1024) begin
            mdl[a] = d[7:0];
            if (ww) mdl[a + 16'd1] = d[15:8];
        end else if (a == 16'hFF00) begin
            m_out = d[7:0];
            if (ww) m_dir = d[15:8];
        end else if (a == 16'hFF01) begin
            m_dir = d[7:0];
        end
    endtask

    // Drive at a falling edge; result is checked at the next falling edge.
    task automatic run_op(input logic we, input logic ww, input logic [15:0] a, input logic [15:0] d);
        logic [7:0] gi;
        logic [15:0] exp;
        gi = 8'($urandom);
        exp = we ? 16'h0000 : exp_read(a, ww, gi);
        wr_en = we; word_wr = ww; addr = a; wdata = d; gpio_i = gi;
        if (we) model_write(ww, a, d);
        @(negedge clk);
        check(tag_of(we, ww, a), "rdata", rdata, exp);
        check("R6", "gpio_o", {8'h00, gpio_o}, {8'h00, m_out});
        check("R6", "gpio_oe", {8'h00, gpio_oe}, {8'h00, m_dir});
        check("R3", "misalign", {15'h0, misalign}, {15'h0, m_mis});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R5: reset state
        check("R5", "rdata in reset", rdata, 16'h0000);
        check("R5", "gpio_o in reset", {8'h00, gpio_o}, 16'h0000);
        check("R5", "gpio_oe in reset", {8'h00, gpio_oe}, 16'h0000);
        check("R5", "misalign in reset", {15'h0, misalign}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5", "rdata after reset", rdata, 16'h0000);

        // Fill RAM by even word writes (R2)
        for (int i = 0; i < 512; i++) run_op(1'b1, 1'b1, 16'(2*i), 16'($urandom));

        // Directed corner cases
        run_op(1'b1, 1'b1, 16'h0010, 16'hBEEF);                           // R2
        run_op(1'b0, 1'b0, 16'h0010, 16'h0);
        check("R2", "low byte of word", rdata, 16'h00EF);
        run_op(1'b0, 1'b0, 16'h0011, 16'h0);
        check("R2", "high byte of word", rdata, 16'h00BE);
        run_op(1'b1, 1'b0, 16'h0011, 16'hAA55);                           // R1
        run_op(1'b0, 1'b1, 16'h0010, 16'h0);
        check("R1", "byte write keeps neighbour", rdata, 16'h55EF);
        run_op(1'b0, 1'b1, 16'h0011, 16'h0);
        check("R4", "odd word read", rdata, 16'h55EF);
        check("R3", "flag clear before odd write", {15'h0, misalign}, 16'h0000);
        run_op(1'b1, 1'b1, 16'h0011, 16'h1234);                           // R3 dropped
        run_op(1'b0, 1'b1, 16'h0010, 16'h0);
        check("R3", "odd word write dropped", rdata, 16'h55EF);
        run_op(1'b1, 1'b1, 16'h03FF, 16'h7777);                           // R3 at top
        run_op(1'b1, 1'b1, 16'h03FE, 16'hC3A5);
        run_op(1'b1, 1'b0, 16'h03FF, 16'h0099);
        run_op(1'b0, 1'b1, 16'h03FE, 16'h0);
        check("R1", "top byte", rdata, 16'h99A5);
        run_op(1'b1, 1'b1, 16'hFF00, 16'hF05A);                           // R6
        check("R6", "word port load out", {8'h00, gpio_o}, 16'h005A);
        check("R6", "word port load dir", {8'h00, gpio_oe}, 16'h00F0);
        run_op(1'b1, 1'b1, 16'hFF01, 16'hFFFF);                           // R3 odd at port
        run_op(1'b0, 1'b1, 16'hFF01, 16'h0);                              // R7
        run_op(1'b1, 1'b0, 16'h0400, 16'h00AB);                           // R8
        run_op(1'b0, 1'b0, 16'h0400, 16'h0);
        run_op(1'b1, 1'b0, 16'hFF02, 16'h00CD);
        run_op(1'b0, 1'b1, 16'hFF02, 16'h0);
        run_op(1'b0, 1'b1, 16'hFFFF, 16'h0);
        run_op(1'b0, 1'b0, 16'h0000, 16'h0);                              // R8 no alias
        run_op(1'b0, 1'b0, 16'h0001, 16'h0);

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int sel;
            logic [15:0] a;
            sel = int'($urandom % 10);
            if (sel < 6)       a = 16'($urandom % 1024);
            else if (sel < 8)  a = 16'hFF00 | 16'($urandom % 2);
            else               a = 16'h0400 + 16'($urandom % 16'hFB00);
            run_op(($urandom % 3) == 0, ($urandom % 2) == 0, a, 16'($urandom));
        end

        // Reset clears the sticky flag (R3)
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_mis = 1'b0; m_out = '0; m_dir = '0;
        @(negedge clk);
        check("R3", "flag cleared by reset", {15'h0, misalign}, 16'h0000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule